// File: doc/BRIEF.md
# H-Bridge Switch Sequencer

This block sits between the digital control inputs of a full-bridge motor driver and its four gate drivers. It accepts an active-low brake request, an active-high disable, a direction select, a decay-style select, a chop request from the current regulator and a fault flag from the thermal and supply monitors. From these it produces registered on/off commands for the upper and lower switch of bridge leg A and of bridge leg B.

The command pattern follows a fixed priority. A fault wins over everything. Braking comes next, then the disable input, then normal drive. In normal drive, the chop request selects the recirculation pattern named by the decay-style select. Each leg has its own sequencer. Whenever a switch is asked to turn on while its partner in the same leg has just turned off, the sequencer holds both switches of that leg off for a programmable number of clock cycles. Two status flags tell a parked bridge in low-power sleep apart from plain standby. A crossover-active flag, with an end pulse, lets the current regulator start its blanking interval once the bridge has actually switched.

Top module: `hbr_switch_ctrl`

## Requirements
- R1: With `fault` low and `brake_n` low, both upper switches are off from the first clock edge. Both lower switches are on once any dead time has run. This holds whatever `enable`, `phase`, `mode` and `chop` are.
- R2: With `fault` low, `brake_n` high and `enable` high, all four switch outputs are low from the first clock edge.
- R3: `sleep` is 1 when `brake_n`, `enable` and `mode` are all high. `standby` is 1 when `brake_n` and `enable` are high and `mode` is low. In every other case both flags are 0. Both flags are registered, one cycle after the inputs.
- R4: With `brake_n` high, `enable` low and `chop` low, `phase`=1 turns on `hs_a` and `ls_b`, and `phase`=0 turns on `hs_b` and `ls_a`.
- R5: With `brake_n` high, `enable` low, `chop` high and `mode` low (slow decay), both upper switches are off and both lower switches are on.
- R6: With `brake_n` high, `enable` low, `chop` high and `mode` high (fast decay), the pair opposite to the one that `phase` selects is on. `phase`=1 gives `hs_b` and `ls_a`; `phase`=0 gives `hs_a` and `ls_b`.
- R7: `fault` high makes all four switch outputs low from the next clock edge, whatever the other inputs are. It does not change `sleep` or `standby`.
- R8: In no cycle are the upper and lower switch of the same leg on together.
- R9: When a switch must turn on after its partner in the same leg turned off, both switches of that leg stay off for exactly DEAD_CYC cycles, and the switch turns on at the next edge. A switch whose partner did not just turn off turns on one cycle after the input change.
- R10: `xover_act` is 1 in exactly those cycles in which a requested turn-on is being held back. `xover_end` is 1 for one cycle: the cycle in which the held switch turns on.
- R11: While `rst` is high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brake_n | input | 1 | Brake request, active low |
| enable | input | 1 | High disables all switches |
| phase | input | 1 | Direction select, 1 = current from A to B |
| mode | input | 1 | Decay select, 1 = fast, 0 = slow; with enable high, 1 = sleep |
| chop | input | 1 | Off-interval request from the current regulator |
| fault | input | 1 | Thermal or undervoltage fault, forces all switches off |
| hs_a | output | 1 | Upper switch, leg A |
| ls_a | output | 1 | Lower switch, leg A |
| hs_b | output | 1 | Upper switch, leg B |
| ls_b | output | 1 | Lower switch, leg B |
| sleep | output | 1 | Bridge parked in low-power sleep |
| standby | output | 1 | Bridge parked in standby |
| xover_act | output | 1 | Crossover delay in progress |
| xover_end | output | 1 | One-cycle pulse when the delayed switch turns on |

## Verification
The bench builds the block with DEAD_CYC = 4 instead of the default 25. This keeps every hold window short, so the bench can sample each cycle of a crossover one by one and confirm its exact start, its length and the end pulse. The short window also lets one table walk step through every priority case: fault over brake, brake over disable, sleep against standby, and both decay styles in both directions, with a settle time of only a few cycles. Directed cases cover the three kinds of turn-on that differ only in timing: a turn-on that waits after its partner drops, an immediate re-enable of the same switch, and recovery from a fault.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    localparam int NUM_LEGS = 2;
    localparam int LEG_A    = 0;
    localparam int LEG_B    = 1;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_t;

    typedef leg_t [NUM_LEGS-1:0] bridge_t;

    typedef struct packed {
        logic brake_n;
        logic enable;
        logic phase;
        logic mode;
        logic chop;
        logic fault;
    } ctrl_t;

    typedef enum logic [2:0] {
        ST_FAULT,
        ST_BRAKE,
        ST_PARKED,
        ST_DRIVE,
        ST_SLOW,
        ST_FAST
    } bridge_state_e;

    localparam leg_t LEG_OFF = '{hi: 1'b0, lo: 1'b0};
    localparam leg_t LEG_HI  = '{hi: 1'b1, lo: 1'b0};
    localparam leg_t LEG_LO  = '{hi: 1'b0, lo: 1'b1};

    function automatic bridge_state_e classify(input ctrl_t c);
        bridge_state_e s;
        if (c.fault)         s = ST_FAULT;
        else if (!c.brake_n) s = ST_BRAKE;
        else if (c.enable)   s = ST_PARKED;
        else if (!c.chop)    s = ST_DRIVE;
        else if (!c.mode)    s = ST_SLOW;
        else                 s = ST_FAST;
        return s;
    endfunction

    function automatic bridge_t target_of(input bridge_state_e s, input logic ph);
        bridge_t t;
        t = '{default: LEG_OFF};
        case (s)
            ST_BRAKE, ST_SLOW: begin
                t[LEG_A] = LEG_LO;
                t[LEG_B] = LEG_LO;
            end
            ST_DRIVE: begin
                t[LEG_A] = ph ? LEG_HI : LEG_LO;
                t[LEG_B] = ph ? LEG_LO : LEG_HI;
            end
            ST_FAST: begin
                t[LEG_A] = ph ? LEG_LO : LEG_HI;
                t[LEG_B] = ph ? LEG_HI : LEG_LO;
            end
            default: t = '{default: LEG_OFF};
        endcase
        return t;
    endfunction

endpackage

// File: rtl/hbr_decode.sv
module hbr_decode
    import hbr_pkg::*;
(
    input  ctrl_t   ctrl,
    output bridge_t target,
    output logic    sleep_d,
    output logic    standby_d
);

    bridge_state_e state;

    always_comb begin
        state     = classify(ctrl);
        target    = target_of(state, ctrl.phase);
        sleep_d   = ctrl.brake_n & ctrl.enable & ctrl.mode;
        standby_d = ctrl.brake_n & ctrl.enable & ~ctrl.mode;
    end

endmodule

// File: rtl/hbr_leg.sv
module hbr_leg
    import hbr_pkg::*;
#(
    parameter int DEAD_CYC = 25
) (
    input  logic clk,
    input  logic rst,
    input  leg_t tgt,
    output leg_t cmd,
    output logic blocked
);

    localparam int CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYC - 1);

    leg_t          cmd_q;
    leg_t          cmd_d;
    logic [CW-1:0] gap_q;
    logic          last_hi_q;
    logic          guard;
    logic          fall_hi;
    logic          fall_lo;

    always_comb begin
        guard    = (gap_q != '0);
        cmd_d.hi = tgt.hi & ~cmd_q.lo & ~(guard & ~last_hi_q);
        cmd_d.lo = tgt.lo & ~tgt.hi & ~cmd_q.hi & ~(guard & last_hi_q);
        fall_hi  = cmd_q.hi & ~cmd_d.hi;
        fall_lo  = cmd_q.lo & ~cmd_d.lo;
        blocked  = (tgt.hi & ~cmd_d.hi) | (tgt.lo & ~tgt.hi & ~cmd_d.lo);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= LEG_OFF;
            gap_q     <= '0;
            last_hi_q <= 1'b0;
        end else begin
            cmd_q <= cmd_d;
            if (fall_hi || fall_lo) begin
                gap_q     <= RELOAD;
                last_hi_q <= fall_hi;
            end else if (guard) begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

    assign cmd = cmd_q;

    // R8: never both switches of this leg on
    p_leg_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(cmd_q.hi && cmd_q.lo));

    // R9: an upper turn-on is preceded by a cycle with the lower switch off
    p_gap_hi_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_q.hi) |-> $past(!cmd_q.lo));

    // R9: a lower turn-on is preceded by a cycle with the upper switch off
    p_gap_lo_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_q.lo) |-> $past(!cmd_q.hi));

endmodule

// File: rtl/hbr_switch_ctrl.sv
module hbr_switch_ctrl
    import hbr_pkg::*;
#(
    parameter int DEAD_CYC = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic brake_n,
    input  logic enable,
    input  logic phase,
    input  logic mode,
    input  logic chop,
    input  logic fault,
    output logic hs_a,
    output logic ls_a,
    output logic hs_b,
    output logic ls_b,
    output logic sleep,
    output logic standby,
    output logic xover_act,
    output logic xover_end
);

    ctrl_t               ctrl;
    bridge_t             target;
    bridge_t             cmd;
    logic [NUM_LEGS-1:0] leg_blocked;
    logic                sleep_d;
    logic                standby_d;
    logic                sleep_q;
    logic                standby_q;
    logic                xact_q;
    logic                xend_q;
    logic                any_blocked;

    assign ctrl = '{brake_n: brake_n, enable: enable, phase: phase,
                    mode: mode, chop: chop, fault: fault};

    hbr_decode u_decode (
        .ctrl      (ctrl),
        .target    (target),
        .sleep_d   (sleep_d),
        .standby_d (standby_d)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hbr_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk     (clk),
            .rst     (rst),
            .tgt     (target[g]),
            .cmd     (cmd[g]),
            .blocked (leg_blocked[g])
        );
    end

    assign any_blocked = |leg_blocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            sleep_q   <= 1'b0;
            standby_q <= 1'b0;
            xact_q    <= 1'b0;
            xend_q    <= 1'b0;
        end else begin
            sleep_q   <= sleep_d;
            standby_q <= standby_d;
            xact_q    <= any_blocked;
            xend_q    <= xact_q & ~any_blocked;
        end
    end

    assign hs_a      = cmd[LEG_A].hi;
    assign ls_a      = cmd[LEG_A].lo;
    assign hs_b      = cmd[LEG_B].hi;
    assign ls_b      = cmd[LEG_B].lo;
    assign sleep     = sleep_q;
    assign standby   = standby_q;
    assign xover_act = xact_q;
    assign xover_end = xend_q;

    // R7: fault clears every switch at the next edge
    p_fault_off_r7: assert property (@(posedge clk) disable iff (rst)
        fault |=> !(hs_a || ls_a || hs_b || ls_b));

    // R1: braking drops both upper switches at the next edge
    p_brake_hs_off_r1: assert property (@(posedge clk) disable iff (rst)
        !brake_n |=> !(hs_a || hs_b));

    // R2: disable clears every switch at the next edge
    p_enable_off_r2: assert property (@(posedge clk) disable iff (rst)
        (brake_n && enable) |=> !(hs_a || ls_a || hs_b || ls_b));

    // R3: the two parked flags never show together
    p_status_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(sleep && standby));

    // R10: the end pulse follows a cycle of active crossover
    p_xend_r10: assert property (@(posedge clk) disable iff (rst)
        xover_end |-> ($past(xover_act) && !xover_act));

endmodule

// File: tb/hbr_switch_ctrl_tb.sv
module hbr_switch_ctrl_tb;

    localparam int DEAD = 4;
    localparam int SETTLE = DEAD + 3;
    localparam int NVEC = 14;

    // vector: {brake_n, enable, phase, mode, chop, fault, hs_a, ls_a, hs_b, ls_b, sleep, standby}
    localparam logic [11:0] VEC [NVEC] = '{
        12'b1_0_1_0_0_0_1001_00,  // R4 forward
        12'b1_0_0_0_0_0_0110_00,  // R4 reverse
        12'b1_0_1_0_1_0_0101_00,  // R5 forward slow chop
        12'b1_0_0_0_1_0_0101_00,  // R5 reverse slow chop
        12'b1_0_1_1_1_0_0110_00,  // R6 forward fast chop
        12'b1_0_0_1_1_0_1001_00,  // R6 reverse fast chop
        12'b1_0_1_1_0_0_1001_00,  // R4 forward, fast select, no chop
        12'b1_1_1_1_0_0_0000_10,  // R2 R3 sleep
        12'b1_1_0_0_1_0_0000_01,  // R2 R3 standby, chop ignored
        12'b0_0_1_0_0_0_0101_00,  // R1 brake
        12'b0_1_1_1_1_0_0101_00,  // R1 brake over enable
        12'b1_0_1_0_0_1_0000_00,  // R7 fault in drive
        12'b0_0_0_0_0_1_0000_00,  // R7 fault over brake
        12'b1_1_1_1_0_1_0000_10   // R7 fault while asleep
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic brake_n = 1'b1, enable = 1'b1, phase = 1'b0, mode = 1'b0, chop = 1'b0, fault = 1'b0;
    logic hs_a, ls_a, hs_b, ls_b, sleep, standby, xover_act, xover_end;

    int n_chk = 0;
    int n_bad = 0;
    int excl_bad = 0;

    always #10 clk = ~clk;

    hbr_switch_ctrl #(.DEAD_CYC(DEAD)) u_dut (
        .clk(clk), .rst(rst), .brake_n(brake_n), .enable(enable), .phase(phase),
        .mode(mode), .chop(chop), .fault(fault), .hs_a(hs_a), .ls_a(ls_a),
        .hs_b(hs_b), .ls_b(ls_b), .sleep(sleep), .standby(standby),
        .xover_act(xover_act), .xover_end(xover_end)
    );

    // R8 monitor, every cycle
    always @(negedge clk) begin
        if (!rst && ((hs_a && ls_a) || (hs_b && ls_b))) excl_bad++;
    end

    function automatic logic [7:0] obs();
        return {hs_a, ls_a, hs_b, ls_b, sleep, standby, xover_act, xover_end};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (hsA lsA hsB lsB slp stb xact xend)", req, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] c);
        {brake_n, enable, phase, mode, chop, fault} = c;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string tag_of(input logic [5:0] c);
        if (c[0])       return "R7";
        if (!c[5])      return "R1";
        if (c[4])       return "R2 R3";
        if (!c[1])      return "R4";
        if (c[2])       return "R6";
        return "R5";
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R11: reset state
        cyc(3);
        chk("R11 reset", obs(), 8'b0000_0000);
        @(negedge clk);
        rst = 1'b0;

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][11:6]);
            cyc(SETTLE);
            chk(tag_of(VEC[i][11:6]), obs(), {VEC[i][5:0], 2'b00});
        end

        // R9 R10: direction reversal with dead time on both legs
        drive(6'b1_0_1_0_0_0);
        cyc(SETTLE);
        chk("R4 forward before reversal", obs(), 8'b1001_00_00);
        phase = 1'b0;
        for (int k = 1; k <= DEAD; k++) begin
            @(negedge clk);
            chk("R9 R10 hold window", obs(), 8'b0000_00_10);
        end
        @(negedge clk);
        chk("R9 R10 reverse on after hold", obs(), 8'b0110_00_01);
        @(negedge clk);
        chk("R10 end pulse one cycle", obs(), 8'b0110_00_00);

        // R2 then R9: disable and immediate re-enable of same switches
        enable = 1'b1;
        @(negedge clk);
        chk("R2 disable next edge", obs(), 8'b0000_01_00);
        enable = 1'b0;
        @(negedge clk);
        chk("R9 re-enable without hold", obs(), 8'b0110_00_00);

        // R7: fault, then recovery without hold
        fault = 1'b1;
        @(negedge clk);
        chk("R7 fault next edge", obs(), 8'b0000_00_00);
        fault = 1'b0;
        @(negedge clk);
        chk("R7 R9 recovery after fault", obs(), 8'b0110_00_00);

        // R1: brake from reverse drive, leg B waits, leg A low side stays
        brake_n = 1'b0;
        @(negedge clk);
        chk("R1 brake upper off", obs(), 8'b0100_00_10);
        cyc(DEAD - 1);
        chk("R1 R9 brake still held", obs(), 8'b0100_00_10);
        @(negedge clk);
        chk("R1 brake both lower on", obs(), 8'b0101_00_01);

        // R5: slow-decay chop from forward drive
        drive(6'b1_0_1_0_0_0);
        cyc(SETTLE);
        chop = 1'b1;
        @(negedge clk);
        chk("R5 chop upper off at once", obs(), 8'b0001_00_10);
        cyc(DEAD);
        chk("R5 R9 chop lower A on", obs(), 8'b0101_00_01);

        // R3: status latency of one cycle
        drive(6'b1_1_1_1_0_0);
        @(negedge clk);
        chk("R3 sleep after one edge", obs(), 8'b0000_10_00);
        mode = 1'b0;
        @(negedge clk);
        chk("R3 standby after one edge", obs(), 8'b0000_01_00);

        // R11: reset mid-run
        drive(6'b1_0_1_0_0_0);
        cyc(SETTLE);
        rst = 1'b1;
        @(negedge clk);
        chk("R11 reset mid-run", obs(), 8'b0000_00_00);
        rst = 1'b0;

        // R8: exclusivity over the whole run
        chk("R8 leg exclusivity", 8'(excl_bad), 8'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule